// File: doc/BRIEF.md
# Virtually Tagged Read Cache with Owner Process ID

This block is a small, direct-mapped, read-only cache that is indexed and tagged with the virtual address. A lookup needs no address translation first. Each line also records the process ID that loaded it. A lookup hits only when the line is valid, its virtual tag matches, and its recorded owner ID equals the ID that comes with the lookup. Two processes that use the same virtual address land on the same line and take turns evicting each other.

On a miss, the block asks the backing memory for one word using a valid/ready handshake. It sends the virtual address and the process ID. It then waits for the response, installs the word with the requesting ID, and returns the data with the hit flag low. A purge command takes a process ID and walks every line, one per cycle. It clears each line that this ID owns. The operating system issues it when a process ends, so that a later process given the same ID cannot hit on stale lines. Lookups are refused while the purge runs.

The control is a five-state machine:
- `ST_IDLE`: waits for a command.
- `ST_CHECK`: compares the stored line with the captured request.
- `ST_MEM_REQ`: presents the refill request.
- `ST_MEM_WAIT`: waits for the refill data.
- `ST_SWEEP`: runs the purge.

Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→SWEEP | purge command |
| IDLE→CHECK | lookup accepted and no purge command |
| CHECK→IDLE | hit |
| CHECK→MEM_REQ | miss |
| MEM_REQ→MEM_WAIT | memory accepts the request |
| MEM_WAIT→IDLE | refill data arrives |
| SWEEP→IDLE | after the last line is visited |

Top module: `vtag_cache`

## Requirements
- R1: After reset every line is invalid, so the first lookup of any address misses. Directly after reset `req_ready` is 1, and `busy`, `rsp_valid` and `mem_req_valid` are 0.
- R2: On a miss, `mem_req_valid` rises two clock edges after the lookup is accepted. `mem_req_addr` equals the lookup address and `mem_req_pid` equals the lookup ID. All three hold steady until `mem_req_ready` is seen high.
- R3: On the edge where `mem_rsp_valid` is high in the wait state, the line is written with `mem_rsp_data`, the lookup's tag and the lookup's ID. After that edge `rsp_valid`=1, `rsp_hit`=0 and `rsp_data` equals the refill word.
- R4: A lookup hits when the indexed line is valid, its tag matches and its stored ID matches. Then, after the second edge following acceptance, `rsp_valid`=1, `rsp_hit`=1 and `rsp_data` is the stored word, with no memory request.
- R5: A lookup of an address cached by another process ID misses. Its refill replaces the line, so the first ID then misses on that address.
- R6: The line index is `vaddr[5:2]` and the tag is `vaddr[31:6]`. Addresses with different indexes coexist. Addresses with the same index and different tags evict each other.
- R7: A purge command accepted in idle raises `busy` for exactly `LINES` cycles. `req_ready` is 0 while `busy` is high.
- R8: A purge clears only lines whose stored ID equals `inv_pid`. Lines owned by other IDs still hit afterwards.
- R9: When a purge command and a lookup are both present in idle, the purge wins. `req_ready` is 0 while `inv_valid` is high, and no response or memory request occurs during the purge.
- R10: Only one lookup is in flight. `req_ready` is 0 from the edge after acceptance until the response. `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | 32 | Virtual byte address of the word |
| req_pid | input | 4 | Process ID of the requester |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from the cache without refill |
| rsp_data | output | 32 | Response word |
| inv_valid | input | 1 | Purge command for one process ID |
| inv_pid | input | 4 | Process ID to purge |
| busy | output | 1 | Purge in progress |
| mem_req_valid | output | 1 | Refill request to backing memory |
| mem_req_ready | input | 1 | Backing memory accepts the request |
| mem_req_addr | output | 32 | Virtual address to refill |
| mem_req_pid | output | 4 | Process ID of the refill |
| mem_rsp_valid | input | 1 | Refill word present |
| mem_rsp_data | input | 32 | Refill word |

## Verification
A hit's response is due after the second clock edge following acceptance. A miss raises its memory request at that same point. The miss response follows the edge on which refill data is presented. A purge keeps `busy` high for sixteen cycles counted from the edge after the command.

Each task drives inputs on the falling edge. It then steps one falling edge at a time and samples every output at the exact falling edge where the result is due. It also checks that the response is absent one edge earlier. The refill handshake is held off for one extra cycle to observe that the request stays steady.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_MEM_REQ,
        ST_MEM_WAIT,
        ST_SWEEP
    } vtc_state_e;

endpackage

// File: rtl/vtc_line_store.sv
module vtc_line_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 26,
    parameter int PID_W  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  line_idx,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [PID_W-1:0]  fill_pid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              clr_en,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [PID_W-1:0]  rd_pid,
    output logic [DATA_W-1:0] rd_data
);

    logic [LINES-1:0]  valid_all;
    logic [TAG_W-1:0]  tag_all  [LINES];
    logic [PID_W-1:0]  pid_all  [LINES];
    logic [DATA_W-1:0] data_all [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [PID_W-1:0]  p_q;
        logic [DATA_W-1:0] d_q;
        logic              sel;

        assign sel = (line_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (sel && fill_en) begin
                v_q <= 1'b1;
            end else if (sel && clr_en) begin
                v_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && fill_en) begin
                t_q <= fill_tag;
                p_q <= fill_pid;
                d_q <= fill_data;
            end
        end

        assign valid_all[g] = v_q;
        assign tag_all[g]   = t_q;
        assign pid_all[g]   = p_q;
        assign data_all[g]  = d_q;
    end

    assign rd_valid = valid_all[line_idx];
    assign rd_tag   = tag_all[line_idx];
    assign rd_pid   = pid_all[line_idx];
    assign rd_data  = data_all[line_idx];

endmodule

// File: rtl/vtc_match.sv
module vtc_match #(
    parameter int TAG_W = 26,
    parameter int PID_W = 4
) (
    input  logic             rd_valid,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [PID_W-1:0] rd_pid,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic [PID_W-1:0] cmp_pid,
    input  logic [PID_W-1:0] purge_pid,
    output logic             lookup_hit,
    output logic             purge_own
);

    logic tag_eq;
    logic pid_eq;

    always_comb begin
        tag_eq     = (rd_tag == cmp_tag);
        pid_eq     = (rd_pid == cmp_pid);
        lookup_hit = rd_valid && tag_eq && pid_eq;
        purge_own  = rd_valid && (rd_pid == purge_pid);
    end

endmodule

// File: rtl/vtc_ctrl.sv
module vtc_ctrl
    import vtc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int ADDR_W = 32,
    parameter int PID_W  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [PID_W-1:0]  req_pid,
    output logic              req_ready,
    input  logic              inv_valid,
    input  logic [PID_W-1:0]  inv_pid,
    output logic              busy,
    input  logic              lookup_hit,
    input  logic              purge_own,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  line_idx,
    output logic [TAG_W-1:0]  cmp_tag,
    output logic [PID_W-1:0]  cmp_pid,
    output logic [PID_W-1:0]  purge_pid,
    output logic              fill_en,
    output logic              clr_en,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [PID_W-1:0]  mem_req_pid,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data
);

    vtc_state_e state_q, state_d;

    logic [ADDR_W-1:0] cap_addr_q;
    logic [PID_W-1:0]  cap_pid_q;
    logic [IDX_W-1:0]  sweep_cnt_q;
    logic [PID_W-1:0]  sweep_pid_q;
    logic              sweep_last;
    logic [IDX_W-1:0]  cap_idx;

    assign cap_idx    = cap_addr_q[OFF_W +: IDX_W];
    assign sweep_last = (sweep_cnt_q == IDX_W'(LINES - 1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (inv_valid) begin
                    state_d = ST_SWEEP;
                end else if (req_valid) begin
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                state_d = lookup_hit ? ST_IDLE : ST_MEM_REQ;
            end
            ST_MEM_REQ: begin
                if (mem_req_ready) begin
                    state_d = ST_MEM_WAIT;
                end
            end
            ST_MEM_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SWEEP: begin
                if (sweep_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured request and sweep walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr_q  <= '0;
            cap_pid_q   <= '0;
            sweep_cnt_q <= '0;
            sweep_pid_q <= '0;
        end else begin
            if (state_q == ST_IDLE && inv_valid) begin
                sweep_cnt_q <= '0;
                sweep_pid_q <= inv_pid;
            end else if (state_q == ST_IDLE && req_valid) begin
                cap_addr_q <= req_vaddr;
                cap_pid_q  <= req_pid;
            end else if (state_q == ST_SWEEP) begin
                sweep_cnt_q <= sweep_cnt_q + IDX_W'(1);
            end
        end
    end

    // registered response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_CHECK: begin
                    if (lookup_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_data  <= rd_data;
                    end
                end
                ST_MEM_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_data  <= mem_rsp_data;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // combinational outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE) && !inv_valid;
        busy          = (state_q == ST_SWEEP);
        mem_req_valid = (state_q == ST_MEM_REQ);
        fill_en       = (state_q == ST_MEM_WAIT) && mem_rsp_valid;
        clr_en        = (state_q == ST_SWEEP) && purge_own;
        line_idx      = (state_q == ST_SWEEP) ? sweep_cnt_q : cap_idx;
    end

    assign cmp_tag      = cap_addr_q[ADDR_W-1 -: TAG_W];
    assign cmp_pid      = cap_pid_q;
    assign purge_pid    = sweep_pid_q;
    assign mem_req_addr = cap_addr_q;
    assign mem_req_pid  = cap_pid_q;

endmodule

// File: rtl/vtag_cache.sv
module vtag_cache #(
    parameter int LINES  = 16,
    parameter int ADDR_W = 32,
    parameter int PID_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [PID_W-1:0]  req_pid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              inv_valid,
    input  logic [PID_W-1:0]  inv_pid,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [PID_W-1:0]  mem_req_pid,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - 2;

    logic [IDX_W-1:0]  line_idx;
    logic [TAG_W-1:0]  cmp_tag;
    logic [PID_W-1:0]  cmp_pid;
    logic [PID_W-1:0]  purge_pid;
    logic              fill_en;
    logic              clr_en;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [PID_W-1:0]  rd_pid;
    logic [DATA_W-1:0] rd_data;
    logic              lookup_hit;
    logic              purge_own;

    vtc_ctrl #(
        .LINES (LINES),
        .ADDR_W(ADDR_W),
        .PID_W (PID_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_pid      (req_pid),
        .req_ready    (req_ready),
        .inv_valid    (inv_valid),
        .inv_pid      (inv_pid),
        .busy         (busy),
        .lookup_hit   (lookup_hit),
        .purge_own    (purge_own),
        .rd_data      (rd_data),
        .line_idx     (line_idx),
        .cmp_tag      (cmp_tag),
        .cmp_pid      (cmp_pid),
        .purge_pid    (purge_pid),
        .fill_en      (fill_en),
        .clr_en       (clr_en),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_req_pid  (mem_req_pid),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_data     (rsp_data)
    );

    vtc_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .PID_W (PID_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_idx (line_idx),
        .fill_en  (fill_en),
        .fill_tag (cmp_tag),
        .fill_pid (cmp_pid),
        .fill_data(mem_rsp_data),
        .clr_en   (clr_en),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_pid   (rd_pid),
        .rd_data  (rd_data)
    );

    vtc_match #(
        .TAG_W(TAG_W),
        .PID_W(PID_W)
    ) u_match (
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_pid    (rd_pid),
        .cmp_tag   (cmp_tag),
        .cmp_pid   (cmp_pid),
        .purge_pid (purge_pid),
        .lookup_hit(lookup_hit),
        .purge_own (purge_own)
    );

endmodule

// File: rtl/vtag_cache_checker.sv
module vtag_cache_checker #(
    parameter int LINES  = 16,
    parameter int ADDR_W = 32,
    parameter int PID_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              inv_valid,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [PID_W-1:0]  mem_req_pid
);

    localparam int RUN_W = $clog2(LINES) + 2;

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + RUN_W'(1);
        end else begin
            busy_run <= '0;
        end
    end

    a_r7_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    a_r9_purge_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !req_ready);

    a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_pid)));

    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r10_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

    a_r9_no_mem_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mem_req_valid && !rsp_valid));

    a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < RUN_W'(LINES)));

    a_r7_busy_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == RUN_W'(LINES)));

endmodule

bind vtag_cache vtag_cache_checker #(
    .LINES (LINES),
    .ADDR_W(ADDR_W),
    .PID_W (PID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .inv_valid    (inv_valid),
    .busy         (busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_req_pid  (mem_req_pid)
);

// File: tb/vtag_cache_test.sv
module vtag_cache_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [3:0]  req_pid = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_data;
    logic        inv_valid = 1'b0;
    logic [3:0]  inv_pid = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [3:0]  mem_req_pid;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    vtag_cache uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_pid      (req_pid),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_data     (rsp_data),
        .inv_valid    (inv_valid),
        .inv_pid      (inv_pid),
        .busy         (busy),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_req_pid  (mem_req_pid),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // One lookup; on a miss the memory side answers with fill.
    task automatic lookup(input logic [31:0] va, input logic [3:0] pid,
                          input bit exp_hit, input logic [31:0] exp_data,
                          input logic [31:0] fill, input string req);
        @(negedge clk);
        chk(req_ready == 1'b1, req, "ready before lookup", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        req_pid   = pid;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!rsp_valid && !req_ready, "R10", "in flight one edge after accept",
            {30'd0, rsp_valid, req_ready}, 32'd0);
        @(negedge clk);
        if (exp_hit) begin
            chk(rsp_valid && rsp_hit && !mem_req_valid, req, "hit strobe",
                {29'd0, rsp_valid, rsp_hit, mem_req_valid}, 32'd6);
            chk(rsp_data == exp_data, req, "hit data", rsp_data, exp_data);
            @(negedge clk);
            chk(!rsp_valid, "R10", "response is one cycle", 32'(rsp_valid), 32'd0);
        end else begin
            chk(mem_req_valid && !rsp_valid, req, "miss raises mem request",
                {30'd0, mem_req_valid, rsp_valid}, 32'd2);
            chk(mem_req_addr == va, "R2", "mem address", mem_req_addr, va);
            chk(mem_req_pid == pid, "R2", "mem pid", 32'(mem_req_pid), 32'(pid));
            @(negedge clk);
            chk(mem_req_valid && mem_req_addr == va, "R2", "request held without ready",
                mem_req_addr, va);
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk(!mem_req_valid, "R2", "request drops after handshake",
                32'(mem_req_valid), 32'd0);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = fill;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(rsp_valid && !rsp_hit, "R3", "refill response flags",
                {30'd0, rsp_valid, rsp_hit}, 32'd2);
            chk(rsp_data == fill, "R3", "refill data", rsp_data, fill);
            chk(req_ready == 1'b1, "R10", "ready at response", 32'(req_ready), 32'd1);
        end
    endtask

    // Purge one ID, optionally with a competing lookup in the same cycle.
    task automatic purge(input logic [3:0] pid, input bit with_req);
        int busy_cnt;
        bit stray;
        busy_cnt = 0;
        stray = 1'b0;
        @(negedge clk);
        inv_valid = 1'b1;
        inv_pid   = pid;
        if (with_req) begin
            req_valid = 1'b1;
            req_vaddr = 32'h0000_1004;
            req_pid   = 4'd1;
        end
        #1;
        chk(req_ready == 1'b0, "R9", "ready low with purge pending", 32'(req_ready), 32'd0);
        @(negedge clk);
        inv_valid = 1'b0;
        req_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (!busy) break;
            busy_cnt = busy_cnt + 1;
            if (req_ready || rsp_valid || mem_req_valid) stray = 1'b1;
            @(negedge clk);
        end
        chk(busy_cnt == 16, "R7", "busy length", busy_cnt, 32'd16);
        chk(!stray, with_req ? "R9" : "R7", "no ready/response/request during purge",
            32'(stray), 32'd0);
        chk(req_ready && !rsp_valid, "R9", "idle after purge",
            {30'd0, req_ready, rsp_valid}, 32'd2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        chk(!busy && !rsp_valid && !mem_req_valid, "R1", "quiet after reset",
            {29'd0, busy, rsp_valid, mem_req_valid}, 32'd0);
    endtask

    task automatic t_first_miss_then_hit();
        lookup(32'h0000_1004, 4'd1, 1'b0, 32'h0, 32'hA1A1_0001, "R1");
        lookup(32'h0000_1004, 4'd1, 1'b1, 32'hA1A1_0001, 32'h0, "R4");
    endtask

    task automatic t_pid_compete();
        lookup(32'h0000_1004, 4'd2, 1'b0, 32'h0, 32'hB2B2_0002, "R5");
        lookup(32'h0000_1004, 4'd2, 1'b1, 32'hB2B2_0002, 32'h0, "R5");
        lookup(32'h0000_1004, 4'd1, 1'b0, 32'h0, 32'hA1A1_0001, "R5");
    endtask

    task automatic t_index_tag();
        lookup(32'h0000_1008, 4'd3, 1'b0, 32'h0, 32'hC3C3_0003, "R6");
        lookup(32'h0000_1004, 4'd1, 1'b1, 32'hA1A1_0001, 32'h0, "R6");
        lookup(32'h0000_2004, 4'd1, 1'b0, 32'h0, 32'hD4D4_0004, "R6");
        lookup(32'h0000_1004, 4'd1, 1'b0, 32'h0, 32'hA1A1_0001, "R6");
        lookup(32'h0000_100C, 4'd1, 1'b0, 32'h0, 32'hE5E5_0005, "R6");
    endtask

    task automatic t_purge_selective();
        purge(4'd1, 1'b0);
        lookup(32'h0000_1008, 4'd3, 1'b1, 32'hC3C3_0003, 32'h0, "R8");
        lookup(32'h0000_100C, 4'd1, 1'b0, 32'h0, 32'hE5E5_0005, "R8");
        lookup(32'h0000_1004, 4'd1, 1'b0, 32'h0, 32'hA1A1_0001, "R8");
    endtask

    task automatic t_purge_priority();
        purge(4'd3, 1'b1);
        lookup(32'h0000_1008, 4'd3, 1'b0, 32'h0, 32'hC3C3_0003, "R9");
        lookup(32'h0000_1004, 4'd1, 1'b1, 32'hA1A1_0001, 32'h0, "R9");
    endtask

    initial begin
        t_reset();
        t_first_miss_then_hit();
        t_pid_compete();
        t_index_tag();
        t_purge_selective();
        t_purge_priority();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule